// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Long Unit

This unit decodes and executes one signed 16x16 multiply whose product is added to a 64-bit accumulator held in two 32-bit registers. Each multiplicand is either the upper or the lower halfword of its source register, as chosen by a select bit in the instruction. The unit accepts two encodings through one 32-bit input, and a mode input chooses which one applies. In the wide encoding the input is the whole instruction. In the compact encoding the upper 16 bits of the input are the first halfword and the lower 16 bits are the second.

From the instruction the unit takes four register indices: two multiplicand sources, the high accumulator and the low accumulator. It presents these indices on four read-address ports and expects the register file to return the data in the same cycle. The result is registered. One cycle after an issue the unit presents either a paired writeback or an undefined-instruction flag. The writeback goes to the high and low registers and is qualified by the condition-pass input.

Top module: `hmal_unit`

## Requirements
- R1: With mode_compact=0, an encoding matches only when insn[27:20]=8'b00010100 and insn[7]=1 and insn[4]=0. The fields are: high accumulator insn[19:16], low accumulator insn[15:12], M source insn[11:8], N source insn[3:0], M select insn[6] and N select insn[5].
- R2: With mode_compact=1, the first halfword F=insn[31:16] and the second halfword S=insn[15:0]. An encoding matches only when F[15:4]=12'hFBC and S[7:6]=2'b10. The fields are: N source F[3:0], low accumulator S[15:12], high accumulator S[11:8], N select S[5], M select S[4] and M source S[3:0].
- R3: In the wide encoding, a matching instruction is undefined when any of its four register indices is 15, or when the high and low accumulator indices are equal.
- R4: In the compact encoding, a matching instruction is undefined when any of its four register indices is 13 or 15, or when the high and low accumulator indices are equal.
- R5: A select bit of 1 takes bits [31:16] of the source and a select bit of 0 takes bits [15:0]. The chosen halfword is treated as a signed two's-complement value.
- R6: The result is {high,low} plus the signed product sign-extended to 64 bits, modulo 2^64. A carry or borrow therefore moves from the low word into the high word.
- R7: One cycle after an issue of a legal instruction with cond_pass=1, res_valid=1 and wr_en_hi=wr_en_lo=1. At the same time wr_addr_hi and wr_addr_lo carry the high and low accumulator indices, and wr_data_hi and wr_data_lo carry the upper and lower 32 bits of the result.
- R8: One cycle after an issue of a legal instruction with cond_pass=0, res_valid=1 and both write enables are 0.
- R9: One cycle after an issue of a non-matching or rule-breaking instruction, undef=1, res_valid=0 and both write enables are 0.
- R10: While reset is held, and in the cycle after it, res_valid, undef, wr_en_hi and wr_en_lo are 0.
- R11: One cycle after a cycle with issue_valid=0, res_valid, undef and both write enables are 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction present this cycle |
| mode_compact | input | 1 | 1 selects the compact encoding |
| insn | input | 32 | Instruction word, or two halfwords packed as first:second |
| cond_pass | input | 1 | Condition result for this instruction |
| rd_addr_n | output | 4 | Read index, N multiplicand |
| rd_addr_m | output | 4 | Read index, M multiplicand |
| rd_addr_hi | output | 4 | Read index, high accumulator |
| rd_addr_lo | output | 4 | Read index, low accumulator |
| rd_data_n | input | 32 | Read data for rd_addr_n |
| rd_data_m | input | 32 | Read data for rd_addr_m |
| rd_data_hi | input | 32 | Read data for rd_addr_hi |
| rd_data_lo | input | 32 | Read data for rd_addr_lo |
| res_valid | output | 1 | Registered: legal instruction retired |
| undef | output | 1 | Registered: undefined encoding |
| wr_en_hi | output | 1 | Write enable, high accumulator |
| wr_en_lo | output | 1 | Write enable, low accumulator |
| wr_addr_hi | output | 4 | Write index, high accumulator |
| wr_addr_lo | output | 4 | Write index, low accumulator |
| wr_data_hi | output | 32 | Upper 32 bits of the sum |
| wr_data_lo | output | 32 | Lower 32 bits of the sum |

## Verification
Two things can happen in the same result cycle: the carry from the 32-bit low-word addition into the high word, and the sign extension of the 32-bit product into the upper half. The bench provokes both together by using low accumulator values near 2^32-1 and near 0, with positive and negative products, in every halfword-select combination and in both encodings. Each sum is judged against a 64-bit expected value that the bench computes arithmetically from the register contents it drives. A separate sweep checks that the register rules and the condition input each suppress the writes in the cycle where a result would otherwise appear.

// File: rtl/hmal_pkg.sv
package hmal_pkg;
  localparam int REG_AW = 4;

  typedef struct packed {
    logic [REG_AW-1:0] src_n;
    logic [REG_AW-1:0] src_m;
    logic [REG_AW-1:0] acc_hi;
    logic [REG_AW-1:0] acc_lo;
    logic              sel_n;
    logic              sel_m;
  } hmal_fields_t;
endpackage

// File: rtl/hmal_decode.sv
module hmal_decode
  import hmal_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic          mode_compact,
  input  logic [IW-1:0] insn,
  output hmal_fields_t  fields,
  output logic          legal
);
  localparam int HW = IW / 2;
  localparam logic [REG_AW-1:0] IDX_PC = '1;
  localparam logic [REG_AW-1:0] IDX_SP = IDX_PC - 2;

  logic [HW-1:0] first_hw;
  logic [HW-1:0] second_hw;
  logic          match_wide;
  logic          match_cmp;
  hmal_fields_t  f_wide;
  hmal_fields_t  f_cmp;
  logic          bad_wide;
  logic          bad_cmp;
  logic          unused_cc;

  assign first_hw  = insn[IW-1:HW];
  assign second_hw = insn[HW-1:0];
  assign unused_cc = ^insn[31:28];

  always_comb begin
    match_wide    = (insn[27:20] == 8'b0001_0100) && ((insn[7:4] & 4'b1001) == 4'b1000);
    f_wide.acc_hi = insn[19:16];
    f_wide.acc_lo = insn[15:12];
    f_wide.src_m  = insn[11:8];
    f_wide.src_n  = insn[3:0];
    f_wide.sel_m  = insn[6];
    f_wide.sel_n  = insn[5];
    bad_wide = (f_wide.acc_hi == IDX_PC) || (f_wide.acc_lo == IDX_PC) ||
               (f_wide.src_m == IDX_PC)  || (f_wide.src_n == IDX_PC)  ||
               (f_wide.acc_hi == f_wide.acc_lo);
  end

  always_comb begin
    match_cmp    = (first_hw[15:4] == 12'hFBC) && (second_hw[7:6] == 2'b10);
    f_cmp.src_n  = first_hw[3:0];
    f_cmp.acc_lo = second_hw[15:12];
    f_cmp.acc_hi = second_hw[11:8];
    f_cmp.sel_n  = second_hw[5];
    f_cmp.sel_m  = second_hw[4];
    f_cmp.src_m  = second_hw[3:0];
    bad_cmp = (f_cmp.acc_hi == IDX_PC) || (f_cmp.acc_lo == IDX_PC) ||
              (f_cmp.src_m == IDX_PC)  || (f_cmp.src_n == IDX_PC)  ||
              (f_cmp.acc_hi == IDX_SP) || (f_cmp.acc_lo == IDX_SP) ||
              (f_cmp.src_m == IDX_SP)  || (f_cmp.src_n == IDX_SP)  ||
              (f_cmp.acc_hi == f_cmp.acc_lo);
  end

  always_comb begin
    if (mode_compact) begin
      fields = f_cmp;
      legal  = match_cmp && !bad_cmp;
    end else begin
      fields = f_wide;
      legal  = match_wide && !bad_wide;
    end
  end
endmodule

// File: rtl/hmal_halfsel.sv
module hmal_halfsel #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] value,
  input  logic            sel_top,
  output logic [XLEN-1:0] ext
);
  localparam int H = XLEN / 2;

  always_comb begin
    if (sel_top) ext = {{H{value[XLEN-1]}}, value[XLEN-1:H]};
    else         ext = {{H{value[H-1]}}, value[H-1:0]};
  end
endmodule

// File: rtl/hmal_unit.sv
module hmal_unit
  import hmal_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic              mode_compact,
  input  logic [XLEN-1:0]   insn,
  input  logic              cond_pass,
  output logic [REG_AW-1:0] rd_addr_n,
  output logic [REG_AW-1:0] rd_addr_m,
  output logic [REG_AW-1:0] rd_addr_hi,
  output logic [REG_AW-1:0] rd_addr_lo,
  input  logic [XLEN-1:0]   rd_data_n,
  input  logic [XLEN-1:0]   rd_data_m,
  input  logic [XLEN-1:0]   rd_data_hi,
  input  logic [XLEN-1:0]   rd_data_lo,
  output logic              res_valid,
  output logic              undef,
  output logic              wr_en_hi,
  output logic              wr_en_lo,
  output logic [REG_AW-1:0] wr_addr_hi,
  output logic [REG_AW-1:0] wr_addr_lo,
  output logic [XLEN-1:0]   wr_data_hi,
  output logic [XLEN-1:0]   wr_data_lo
);
  localparam int ACCW = 2 * XLEN;
  localparam int NOPS = 2;

  hmal_fields_t          fld;
  logic                  legal;
  logic [XLEN-1:0]       op_raw [NOPS];
  logic                  op_sel [NOPS];
  logic [XLEN-1:0]       op_ext [NOPS];
  logic signed [XLEN-1:0] prod;
  logic [ACCW-1:0]       acc_in;
  logic [ACCW-1:0]       acc_sum;

  hmal_decode #(.IW(XLEN)) u_dec (
    .mode_compact (mode_compact),
    .insn         (insn),
    .fields       (fld),
    .legal        (legal)
  );

  assign rd_addr_n  = fld.src_n;
  assign rd_addr_m  = fld.src_m;
  assign rd_addr_hi = fld.acc_hi;
  assign rd_addr_lo = fld.acc_lo;

  assign op_raw[0] = rd_data_n;
  assign op_raw[1] = rd_data_m;
  assign op_sel[0] = fld.sel_n;
  assign op_sel[1] = fld.sel_m;

  for (genvar g = 0; g < NOPS; g++) begin : g_opsel
    hmal_halfsel #(.XLEN(XLEN)) u_sel (
      .value   (op_raw[g]),
      .sel_top (op_sel[g]),
      .ext     (op_ext[g])
    );
  end

  always_comb begin
    prod    = $signed(op_ext[0]) * $signed(op_ext[1]);
    acc_in  = {rd_data_hi, rd_data_lo};
    acc_sum = acc_in + {{XLEN{prod[XLEN-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      undef      <= 1'b0;
      wr_en_hi   <= 1'b0;
      wr_en_lo   <= 1'b0;
      wr_addr_hi <= '0;
      wr_addr_lo <= '0;
      wr_data_hi <= '0;
      wr_data_lo <= '0;
    end else begin
      res_valid  <= issue_valid && legal;
      undef      <= issue_valid && !legal;
      wr_en_hi   <= issue_valid && legal && cond_pass;
      wr_en_lo   <= issue_valid && legal && cond_pass;
      wr_addr_hi <= fld.acc_hi;
      wr_addr_lo <= fld.acc_lo;
      wr_data_hi <= acc_sum[ACCW-1:XLEN];
      wr_data_lo <= acc_sum[XLEN-1:0];
    end
  end

  AST_WB_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    wr_en_hi |-> $past(cond_pass) && $past(issue_valid)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !res_valid && !undef && !wr_en_hi && !wr_en_lo); // R11
  AST_UNDEF_NO_WB: assert property (@(posedge clk) disable iff (rst)
    undef |-> !res_valid && !wr_en_hi && !wr_en_lo); // R9
  AST_ACC_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    wr_en_lo |-> wr_addr_hi != wr_addr_lo); // R3
  AST_NO_PC_WRITE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (wr_addr_hi != '1) && (wr_addr_lo != '1)); // R4
  AST_EN_PAIRED: assert property (@(posedge clk) disable iff (rst)
    wr_en_hi == wr_en_lo); // R7
endmodule

// File: tb/test_hmal_unit.sv
module test_hmal_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue_valid;
  logic        mode_compact;
  logic [31:0] insn;
  logic        cond_pass;
  logic [3:0]  rd_addr_n, rd_addr_m, rd_addr_hi, rd_addr_lo;
  logic [31:0] rd_data_n, rd_data_m, rd_data_hi, rd_data_lo;
  logic        res_valid, undef, wr_en_hi, wr_en_lo;
  logic [3:0]  wr_addr_hi, wr_addr_lo;
  logic [31:0] wr_data_hi, wr_data_lo;

  logic [31:0] regs [16];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign rd_data_n  = regs[rd_addr_n];
  assign rd_data_m  = regs[rd_addr_m];
  assign rd_data_hi = regs[rd_addr_hi];
  assign rd_data_lo = regs[rd_addr_lo];

  hmal_unit i_hmal_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .mode_compact(mode_compact),
    .insn(insn), .cond_pass(cond_pass),
    .rd_addr_n(rd_addr_n), .rd_addr_m(rd_addr_m), .rd_addr_hi(rd_addr_hi), .rd_addr_lo(rd_addr_lo),
    .rd_data_n(rd_data_n), .rd_data_m(rd_data_m), .rd_data_hi(rd_data_hi), .rd_data_lo(rd_data_lo),
    .res_valid(res_valid), .undef(undef), .wr_en_hi(wr_en_hi), .wr_en_lo(wr_en_lo),
    .wr_addr_hi(wr_addr_hi), .wr_addr_lo(wr_addr_lo), .wr_data_hi(wr_data_hi), .wr_data_lo(wr_data_lo)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_wide(input logic [3:0] hi, lo, m, n, input logic sm, sn);
    return {4'hE, 8'b0001_0100, hi, lo, m, 1'b1, sm, sn, 1'b0, n};
  endfunction

  function automatic logic [31:0] enc_cmp(input logic [3:0] hi, lo, m, n, input logic sm, sn);
    return {12'hFBC, n, lo, hi, 2'b10, sn, sm, m};
  endfunction

  function automatic logic [63:0] model(input logic [31:0] a, b, h, l, input logic sa, sb);
    logic signed [15:0] x;
    logic signed [15:0] y;
    longint p;
    x = sa ? a[31:16] : a[15:0];
    y = sb ? b[31:16] : b[15:0];
    p = longint'(x) * longint'(y);
    return {h, l} + 64'(p);
  endfunction

  // issue one instruction, sample one cycle later
  task automatic issue(input logic cmp, input logic [31:0] w, input logic cp);
    @(negedge clk);
    mode_compact = cmp; insn = w; cond_pass = cp; issue_valid = 1'b1;
    @(posedge clk); #1;
    issue_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; issue_valid = 1'b0; mode_compact = 1'b0; insn = '0; cond_pass = 1'b0;
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, 64'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R10 after reset", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, 64'd0);

    // R5 R6 R7: all select pairs, both encodings, carry/borrow and sign patterns
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 6; v++) begin
          logic [31:0] a, b, h, l;
          logic [63:0] e;
          case (v)
            0: begin a = 32'h0003_FFFE; b = 32'h0005_0007; h = 32'h1;        l = 32'hFFFF_FFF0; end
            1: begin a = 32'h8000_8000; b = 32'h8000_8000; h = 32'h0;        l = 32'hFFFF_FFFF; end
            2: begin a = 32'hFFFF_7FFF; b = 32'h7FFF_FFFF; h = 32'h0;        l = 32'h0000_0001; end
            3: begin a = 32'h1234_ABCD; b = 32'hFEDC_0042; h = 32'h8000_0000; l = 32'h8000_0000; end
            4: begin a = 32'h7FFF_7FFF; b = 32'h7FFF_7FFF; h = 32'hFFFF_FFFF; l = 32'hC000_0000; end
            default: begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; h = 32'h7; l = 32'hFFFF_FFFF; end
          endcase
          regs[2] = a; regs[3] = b; regs[5] = h; regs[4] = l;
          e = model(a, b, h, l, s[1], s[0]);
          issue(md[0], md[0] ? enc_cmp(4'd5, 4'd4, 4'd3, 4'd2, s[0], s[1])
                             : enc_wide(4'd5, 4'd4, 4'd3, 4'd2, s[0], s[1]), 1'b1);
          chk("R5 R6 R7 sum", {wr_data_hi, wr_data_lo}, e);
          chk("R7 ctrl", {48'd0, res_valid, undef, wr_en_hi, wr_en_lo, wr_addr_hi, wr_addr_lo, 4'd0},
                          {48'd0, 4'b1011, 4'd5, 4'd4, 4'd0});
        end

    // R1 R2: field positions with other register choices
    regs[7] = 32'h0002_0000; regs[9] = 32'h0000_0003; regs[11] = 32'h0; regs[6] = 32'h10;
    issue(1'b0, enc_wide(4'd11, 4'd6, 4'd9, 4'd7, 1'b0, 1'b1), 1'b1);
    chk("R1 wide fields", {wr_addr_hi, wr_addr_lo, wr_data_hi, wr_data_lo}, {4'd11, 4'd6, 32'd0, 32'h16});
    issue(1'b1, enc_cmp(4'd11, 4'd6, 4'd9, 4'd7, 1'b0, 1'b1), 1'b1);
    chk("R2 compact fields", {wr_addr_hi, wr_addr_lo, wr_data_hi, wr_data_lo}, {4'd11, 4'd6, 32'd0, 32'h16});

    // R8: condition false
    issue(1'b0, enc_wide(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0), 1'b0);
    chk("R8 cond false", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b1000});
    issue(1'b1, enc_cmp(4'd5, 4'd4, 4'd3, 4'd2, 1'b1, 1'b1), 1'b0);
    chk("R8 cond false compact", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b1000});

    // R3 R4 R9: rule sweeps; each case lists hi,lo,m,n and expected legality per mode
    for (int c = 0; c < 8; c++) begin
      logic [3:0] hi, lo, m, n;
      logic okw, okc;
      case (c)
        0: begin hi = 4; lo = 4; m = 1; n = 2; okw = 0; okc = 0; end
        1: begin hi = 15; lo = 4; m = 1; n = 2; okw = 0; okc = 0; end
        2: begin hi = 5; lo = 15; m = 1; n = 2; okw = 0; okc = 0; end
        3: begin hi = 5; lo = 4; m = 15; n = 2; okw = 0; okc = 0; end
        4: begin hi = 5; lo = 4; m = 1; n = 15; okw = 0; okc = 0; end
        5: begin hi = 13; lo = 4; m = 1; n = 2; okw = 1; okc = 0; end
        6: begin hi = 5; lo = 4; m = 13; n = 13; okw = 1; okc = 0; end
        default: begin hi = 14; lo = 0; m = 12; n = 1; okw = 1; okc = 1; end
      endcase
      issue(1'b0, enc_wide(hi, lo, m, n, 1'b0, 1'b0), 1'b1);
      chk("R3 R9 wide rule", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo},
          {60'd0, okw, !okw, okw, okw});
      issue(1'b1, enc_cmp(hi, lo, m, n, 1'b0, 1'b0), 1'b1);
      chk("R4 R9 compact rule", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo},
          {60'd0, okc, !okc, okc, okc});
    end

    // R1 R2 R9: pattern mismatches
    issue(1'b0, enc_wide(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0) ^ 32'h0000_0080, 1'b1);
    chk("R1 R9 bit7 clear", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b0100});
    issue(1'b0, enc_wide(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0) ^ 32'h0000_0010, 1'b1);
    chk("R1 R9 bit4 set", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b0100});
    issue(1'b0, enc_wide(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0) ^ 32'h0010_0000, 1'b1);
    chk("R1 R9 opcode", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b0100});
    issue(1'b1, enc_cmp(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0) ^ 32'h0000_0040, 1'b1);
    chk("R2 R9 second hw", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b0100});
    issue(1'b1, enc_cmp(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0) ^ 32'h0100_0000, 1'b1);
    chk("R2 R9 first hw", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b0100});
    issue(1'b1, enc_wide(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0), 1'b1);
    chk("R2 R9 wide word in compact mode", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, {60'd0, 4'b0100});

    // R11: no issue, legal word on the bus
    @(negedge clk);
    mode_compact = 1'b0; insn = enc_wide(4'd5, 4'd4, 4'd3, 4'd2, 1'b0, 1'b0); cond_pass = 1'b1;
    issue_valid = 1'b0;
    @(posedge clk); #1;
    chk("R11 idle", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, 64'd0);
    @(posedge clk); #1;
    chk("R11 idle second", {60'd0, res_valid, undef, wr_en_hi, wr_en_lo}, 64'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule